// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block sits between a synchronous host and a 64K-word by 16-bit asynchronous static RAM. The host hands it one request at a time: a read or write, a 16-bit word address, 16 bits of write data and a two-bit lane mask. The controller turns that request into a pin sequence on the memory's active-low chip select, output enable, write enable and per-byte lane enables. It answers with a single-cycle done pulse, and for reads with the returned word.

Every phase length is a cycle count. The count is derived by rounding up a nanosecond minimum divided by the clock period, and both are parameters. Read access lasts long enough to cover address access, output-enable access and the minimum read cycle. A write has three parts: a setup phase with strobes valid, a write-enable-low pulse that covers the pulse width and the data setup time, and a recovery phase that pads the write out to the minimum write cycle.

The controller drives the data bus only while write enable is low. It places a released turnaround cycle between a read and a following write.

The request side is valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The host must hold the request fields stable while `req_valid` is high and `req_ready` is low. `req_ready` is high only while the controller is idle, so back-pressure lasts for the whole memory operation. The done pulse cannot be stalled: the host must take `rsp_rdata` in the cycle `rsp_valid` is high.

Top module: `sram_ctl`

## Requirements
- R1: While reset is held and after it is released, `req_ready` is 1, `rsp_valid` is 0, `mem_dq_oe` is 0, and `mem_cs_n`, `mem_oe_n`, `mem_we_n` and both bits of `mem_be_n` are 1.
- R2: A request is accepted on an edge with `req_valid` and `req_ready` high. `req_ready` is 0 from the next cycle until the cycle after the done pulse, and the captured request does not change while it is 0.
- R3: A read holds `mem_cs_n` and `mem_oe_n` low with `mem_we_n` high and `mem_addr` equal to the request address for exactly RD_CYC consecutive cycles. RD_CYC is the largest of the rounded-up address access, output/lane enable access and read cycle times.
- R4: Read data is sampled at the end of the last read access cycle. It is presented on `rsp_rdata` with `rsp_valid` high in the single cycle after output enable rises. Bit 0 of the mask selects data bits 7:0 and bit 1 selects bits 15:8, and a lane whose mask bit is 0 returns zero.
- R5: A write holds chip select and the selected lane enables low with write enable high for SETUP_CYC cycles. Write enable is then low for exactly PULSE_CYC cycles, with `mem_dq_oe` high and `mem_dq_out` equal to the write data. PULSE_CYC covers the pulse width and the data setup time, and SETUP_CYC plus PULSE_CYC covers address-valid-to-end-of-write.
- R6: After write enable rises, all strobes stay high for REC_CYC cycles. The done pulse is given in the last of these cycles. SETUP_CYC + PULSE_CYC + REC_CYC covers the write cycle time.
- R7: `mem_dq_oe` is 1 only while `mem_we_n` is 0, and `mem_oe_n` and `mem_we_n` are never both 0.
- R8: A write that follows a read gets one extra cycle with all strobes high before its setup phase. Write enable therefore falls at least four cycles after output enable rose.
- R9: During an operation, lane enable i goes low only if mask bit i is 1. Bit 1 of `mem_be_n` is the upper byte and bit 0 is the lower byte. A mask of 00 still runs the full pin sequence with no lane enabled.
- R10: `rsp_valid` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| req_valid | input | 1 | host request valid |
| req_ready | output | 1 | controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | word address |
| req_wdata | input | 16 | write data |
| req_mask | input | 2 | lane select, bit 1 upper byte, bit 0 lower byte |
| rsp_valid | output | 1 | single-cycle done pulse |
| rsp_rdata | output | 16 | read data, masked lanes zero |
| mem_addr | output | 16 | memory address pins |
| mem_cs_n | output | 1 | chip select, active low |
| mem_oe_n | output | 1 | output enable, active low |
| mem_we_n | output | 1 | write enable, active low |
| mem_be_n | output | 2 | lane enables, active low, bit 1 upper |
| mem_dq_out | output | 16 | data driven toward the memory |
| mem_dq_oe | output | 1 | 1 = controller drives the data bus |
| mem_dq_in | input | 16 | data returned from the memory |

## Verification
The hardest case to reach is the read-to-write turnaround. It only shows when a write is accepted in the first idle cycle after a read's done pulse, because any host gap hides the missing cycle. The driver waits on `req_ready` at each falling edge and issues the write there, so read-then-write pairs run back to back. The bench's memory model only returns valid data once output enable has been low long enough, so a read sampled too early shows up as wrong data.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RD_ACC   = 3'd1,
    ST_RD_DONE  = 3'd2,
    ST_WR_SETUP = 3'd3,
    ST_WR_PULSE = 3'd4,
    ST_WR_RECOV = 3'd5,
    ST_TURN     = 3'd6
  } ctl_state_e;

  // cycles needed to cover a time in ns, rounded up
  function automatic int ns_to_cyc(input int t_ns, input int clk_ns);
    return (t_ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int RD_CYC    = 2,
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 1,
  parameter int REC_CYC   = 1,
  parameter int CNT_W     = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_fire,
  input  logic       req_write,
  output ctl_state_e state,
  output logic       phase_last,
  output logic       req_ready,
  output logic       rsp_valid
);

  logic [CNT_W-1:0] cnt;
  logic             prev_rd;

  assign phase_last = (cnt == '0);
  assign req_ready  = (state == ST_IDLE);
  assign rsp_valid  = (state == ST_RD_DONE) ||
                      ((state == ST_WR_RECOV) && phase_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      prev_rd <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_fire) begin
            if (!req_write) begin
              state   <= ST_RD_ACC;
              cnt     <= CNT_W'(RD_CYC - 1);
              prev_rd <= 1'b1;
            end else if (prev_rd) begin
              state <= ST_TURN;
              cnt   <= '0;
            end else begin
              state <= ST_WR_SETUP;
              cnt   <= CNT_W'(SETUP_CYC - 1);
            end
          end
        end
        ST_RD_ACC: begin
          if (phase_last) state <= ST_RD_DONE;
          else            cnt   <= cnt - 1'b1;
        end
        ST_RD_DONE: state <= ST_IDLE;
        ST_TURN: begin
          state   <= ST_WR_SETUP;
          cnt     <= CNT_W'(SETUP_CYC - 1);
          prev_rd <= 1'b0;
        end
        ST_WR_SETUP: begin
          if (phase_last) begin
            state <= ST_WR_PULSE;
            cnt   <= CNT_W'(PULSE_CYC - 1);
          end else cnt <= cnt - 1'b1;
        end
        ST_WR_PULSE: begin
          if (phase_last) begin
            state <= ST_WR_RECOV;
            cnt   <= CNT_W'(REC_CYC - 1);
          end else cnt <= cnt - 1'b1;
        end
        ST_WR_RECOV: begin
          if (phase_last) state <= ST_IDLE;
          else            cnt   <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R10
  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> req_ready); // R2
  AST_BUSY_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> !req_ready); // R2

endmodule

// File: rtl/sram_ctl_datapath.sv
module sram_ctl_datapath #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_fire,
  input  logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  input  logic              capture,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [LANES-1:0]  mask_q,
  output logic [DATA_W-1:0] rsp_rdata
);

  localparam int LANE_W = DATA_W / LANES;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else if (req_fire) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      mask_q  <= req_mask;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        rsp_rdata[i*LANE_W +: LANE_W] <= '0;
      else if (capture)
        rsp_rdata[i*LANE_W +: LANE_W] <= mask_q[i] ? mem_dq_in[i*LANE_W +: LANE_W]
                                                   : '0;
    end

    AST_MASKED_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (capture && !mask_q[i]) |=> (rsp_rdata[i*LANE_W +: LANE_W] == '0)); // R4
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(addr_q) && $stable(mask_q)); // R2

endmodule

// File: rtl/sram_ctl_pins.sv
module sram_ctl_pins
  import sram_ctl_pkg::*;
#(
  parameter int LANES     = 2,
  parameter int RD_CYC    = 2,
  parameter int PULSE_CYC = 1,
  parameter int RUN_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctl_state_e       state,
  input  logic [LANES-1:0] mask_q,
  output logic             mem_cs_n,
  output logic             mem_oe_n,
  output logic             mem_we_n,
  output logic [LANES-1:0] mem_be_n,
  output logic             mem_dq_oe
);

  logic active;

  assign active    = (state == ST_RD_ACC) || (state == ST_WR_SETUP) ||
                     (state == ST_WR_PULSE);
  assign mem_cs_n  = !active;
  assign mem_oe_n  = (state != ST_RD_ACC);
  assign mem_we_n  = (state != ST_WR_PULSE);
  assign mem_dq_oe = (state == ST_WR_PULSE);

  for (genvar i = 0; i < LANES; i++) begin : g_be
    assign mem_be_n[i] = !(active && mask_q[i]);

    AST_LANE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_be_n[i] |-> mask_q[i]); // R9
  end

  // low-run counters used only by the timing checks below
  logic [RUN_W-1:0] oe_run, we_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_run <= '0;
      we_run <= '0;
    end else begin
      oe_run <= mem_oe_n ? '0 : ((oe_run == '1) ? oe_run : oe_run + 1'b1);
      we_run <= mem_we_n ? '0 : ((we_run == '1) ? we_run : we_run + 1'b1);
    end
  end

  AST_NO_OE_WE_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n)); // R7
  AST_DRIVE_ONLY_WE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_we_n && mem_oe_n)); // R7
  AST_WE_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_cs_n); // R5
  AST_WE_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_run == RUN_W'(PULSE_CYC))); // R5
  AST_OE_ACCESS_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (oe_run == RUN_W'(RD_CYC))); // R3

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int LANES   = 2,
  parameter int CLK_NS  = 10,
  parameter int T_AA_NS = 15,
  parameter int T_RC_NS = 15,
  parameter int T_OE_NS = 8,
  parameter int T_BE_NS = 8,
  parameter int T_WC_NS = 15,
  parameter int T_WP_NS = 10,
  parameter int T_DW_NS = 8,
  parameter int T_AW_NS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [LANES-1:0]  mem_be_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int RD_CYC    = imax(1, imax(ns_to_cyc(T_AA_NS, CLK_NS),
                                  imax(ns_to_cyc(T_RC_NS, CLK_NS),
                                  imax(ns_to_cyc(T_OE_NS, CLK_NS),
                                       ns_to_cyc(T_BE_NS, CLK_NS)))));
  localparam int PULSE_CYC = imax(1, imax(ns_to_cyc(T_WP_NS, CLK_NS),
                                          ns_to_cyc(T_DW_NS, CLK_NS)));
  localparam int SETUP_CYC = imax(1, ns_to_cyc(T_AW_NS, CLK_NS) - PULSE_CYC);
  localparam int REC_CYC   = imax(1, ns_to_cyc(T_WC_NS, CLK_NS) - SETUP_CYC - PULSE_CYC);
  localparam int MAX_CYC   = imax(RD_CYC, imax(PULSE_CYC, imax(SETUP_CYC, REC_CYC)));
  localparam int CNT_W     = imax(1, $clog2(MAX_CYC));
  localparam int RUN_W     = $clog2(MAX_CYC + 2) + 1;

  ctl_state_e        state;
  logic              phase_last;
  logic              req_fire;
  logic              capture;
  logic [LANES-1:0]  mask_q;

  assign req_fire = req_valid && req_ready;
  assign capture  = (state == ST_RD_ACC) && phase_last;

  sram_ctl_fsm #(
    .RD_CYC(RD_CYC), .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC),
    .REC_CYC(REC_CYC), .CNT_W(CNT_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_fire(req_fire), .req_write(req_write),
    .state(state), .phase_last(phase_last), .req_ready(req_ready),
    .rsp_valid(rsp_valid)
  );

  sram_ctl_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .req_fire(req_fire), .req_ready(req_ready),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .capture(capture), .mem_dq_in(mem_dq_in), .addr_q(mem_addr),
    .wdata_q(mem_dq_out), .mask_q(mask_q), .rsp_rdata(rsp_rdata)
  );

  sram_ctl_pins #(
    .LANES(LANES), .RD_CYC(RD_CYC), .PULSE_CYC(PULSE_CYC), .RUN_W(RUN_W)
  ) u_pins (
    .clk(clk), .rst_n(rst_n), .state(state), .mask_q(mask_q),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_be_n(mem_be_n), .mem_dq_oe(mem_dq_oe)
  );

  AST_ADDR_STABLE_IN_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr)); // R3

endmodule

// File: tb/sim_sram_ctl.sv
module sim_sram_ctl;

  localparam int CLK_NS = 5;
  // phase lengths from the requirements at a 5 ns clock
  localparam int E_RD    = 3;  // 15 ns access / read cycle
  localparam int E_PULSE = 2;  // 10 ns pulse, 8 ns data setup
  localparam int E_SETUP = 1;  // 10 ns address-to-end minus pulse, at least 1
  localparam int E_REC   = 1;  // 15 ns write cycle minus 3, at least 1

  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0, req_write = 0;
  logic [15:0] req_addr = 0, req_wdata = 0;
  logic [1:0]  req_mask = 0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata, mem_addr, mem_dq_out;
  logic        mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [1:0]  mem_be_n;
  logic [15:0] mem_dq_in = 16'h5A5A;

  always #2.5 clk = ~clk;

  sram_ctl #(.CLK_NS(CLK_NS)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_be_n(mem_be_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  typedef struct { bit wr; logic [15:0] data; } item_t;
  item_t       sb[$];
  logic [15:0] shadow [int];   // expected contents
  logic [15:0] dev    [int];   // memory model contents
  logic [1:0]  cur_mask;
  logic [15:0] cur_wdata;

  task automatic issue(input bit wr, input logic [15:0] a, input logic [15:0] d,
                       input logic [1:0] m);
    item_t it;
    logic [15:0] old;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    cur_mask = m; cur_wdata = d;
    old = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0;
    it.wr = wr;
    if (wr) begin
      if (m[0]) old[7:0]  = d[7:0];
      if (m[1]) old[15:8] = d[15:8];
      shadow[int'(a)] = old;
      it.data = 16'h0;
    end else begin
      it.data = {m[1] ? old[15:8] : 8'h00, m[0] ? old[7:0] : 8'h00};
    end
    sb.push_back(it);
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 1'b0, "R2 busy after accept", req_ready, 0);
  endtask

  // memory model, pin timing checks and scoreboard monitor
  int cyc = 0, oe_run = 0, we_run = 0, su_run = 0, rd_run = 0;
  int oe_rise_cyc = -100, we_rise_cyc = -100;
  bit after_read = 0, p_rsp = 0;
  logic [1:0]  lane_seen = 0;
  logic        p_cs_n = 1, p_oe_n = 1, p_we_n = 1, p_dq_oe = 0;
  logic [1:0]  p_be_n = 2'b11;
  logic [15:0] p_addr = 0, p_dq_out = 0;

  always @(negedge clk) if (rst_n) begin
    item_t it;
    logic [15:0] w;
    cyc++;
    // output enable rises: access length and lanes used
    if (!p_oe_n && mem_oe_n) begin
      chk(oe_run == E_RD, "R3 read access cycles", oe_run, E_RD);
      chk(lane_seen == cur_mask, "R9 lanes enabled on read", lane_seen, cur_mask);
      oe_rise_cyc = cyc; after_read = 1; lane_seen = 0;
    end
    // write enable falls: setup length, turnaround after read
    if (p_we_n && !mem_we_n) begin
      chk(su_run == E_SETUP, "R5 write setup cycles", su_run, E_SETUP);
      chk(mem_be_n == ~cur_mask, "R9 lanes enabled on write", mem_be_n, ~cur_mask);
      if (after_read)
        chk(cyc - oe_rise_cyc >= 4, "R8 turnaround gap", cyc - oe_rise_cyc, 4);
      after_read = 0;
    end
    // write enable rises: pulse length, driven data, commit to model
    if (!p_we_n && mem_we_n) begin
      chk(we_run == E_PULSE, "R5 write pulse cycles", we_run, E_PULSE);
      chk(p_dq_oe == 1'b1 && p_oe_n, "R7 bus driven in pulse", p_dq_oe, 1);
      chk(p_dq_out == cur_wdata, "R5 write data on bus", p_dq_out, cur_wdata);
      chk(mem_dq_oe == 1'b0, "R7 bus released after pulse", mem_dq_oe, 0);
      w = dev.exists(int'(p_addr)) ? dev[int'(p_addr)] : 16'h0;
      if (!p_be_n[0]) w[7:0]  = p_dq_out[7:0];
      if (!p_be_n[1]) w[15:8] = p_dq_out[15:8];
      dev[int'(p_addr)] = w;
      we_rise_cyc = cyc;
    end
    if (mem_dq_oe && mem_we_n) chk(0, "R7 bus driven outside pulse", 1, 0);
    if (!mem_oe_n && !mem_we_n) chk(0, "R7 oe and we both low", 1, 0);
    // done pulses
    if (rsp_valid) begin
      chk(!p_rsp, "R10 single-cycle done", p_rsp, 0);
      if (sb.size() == 0) chk(0, "R4 unexpected done", 1, 0);
      else begin
        it = sb.pop_front();
        if (it.wr) begin
          chk(cyc - we_rise_cyc == E_REC - 1, "R6 done at end of recovery",
              cyc - we_rise_cyc, E_REC - 1);
          chk(mem_cs_n && mem_we_n && mem_be_n == 2'b11, "R6 strobes high in recovery",
              {mem_cs_n, mem_we_n, mem_be_n}, 4'hF);
        end else begin
          chk(cyc == oe_rise_cyc, "R4 done after oe rise", cyc, oe_rise_cyc);
          chk(rsp_rdata == it.data, "R4 read data", rsp_rdata, it.data);
        end
      end
    end
    // run counters
    oe_run = mem_oe_n ? 0 : oe_run + 1;
    we_run = mem_we_n ? 0 : we_run + 1;
    su_run = (!mem_cs_n && mem_we_n && mem_oe_n) ? su_run + 1 : 0;
    if (!mem_oe_n) lane_seen = lane_seen | ~mem_be_n;
    // read model: data valid only after full access time with stable address
    if (!mem_cs_n && !mem_oe_n && mem_we_n)
      rd_run = (!p_cs_n && !p_oe_n && mem_addr == p_addr) ? rd_run + 1 : 1;
    else rd_run = 0;
    if (rd_run >= E_RD) begin
      w = dev.exists(int'(mem_addr)) ? dev[int'(mem_addr)] : 16'h0;
      mem_dq_in <= {mem_be_n[1] ? 8'hA5 : w[15:8], mem_be_n[0] ? 8'hA5 : w[7:0]};
    end else mem_dq_in <= 16'h5A5A;
    p_cs_n = mem_cs_n; p_oe_n = mem_oe_n; p_we_n = mem_we_n; p_be_n = mem_be_n;
    p_addr = mem_addr; p_dq_out = mem_dq_out; p_dq_oe = mem_dq_oe; p_rsp = rsp_valid;
  end

  task automatic check_idle_pins(input string tag);
    chk(req_ready && !rsp_valid && !mem_dq_oe, tag, {req_ready, rsp_valid, mem_dq_oe}, 3'b100);
    chk(mem_cs_n && mem_oe_n && mem_we_n && mem_be_n == 2'b11, tag,
        {mem_cs_n, mem_oe_n, mem_we_n, mem_be_n}, 5'h1F);
  endtask

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    check_idle_pins("R1 in reset");
    rst_n = 1;
    @(negedge clk);
    check_idle_pins("R1 after reset");

    issue(1, 16'h0000, 16'h1234, 2'b11);
    issue(1, 16'hFFFF, 16'hABCD, 2'b11);
    issue(1, 16'hFFFF, 16'h5678, 2'b10);   // upper lane only
    issue(0, 16'h0000, 16'h0, 2'b11);
    issue(0, 16'hFFFF, 16'h0, 2'b11);      // expect 56CD
    issue(0, 16'hFFFF, 16'h0, 2'b01);      // expect 00CD, R4 masked lane
    issue(0, 16'hFFFF, 16'h0, 2'b00);      // R9 no lanes
    issue(1, 16'h0100, 16'h9ABC, 2'b01);   // read then write, R8
    issue(0, 16'h0100, 16'h0, 2'b11);
    issue(1, 16'h0100, 16'hEF00, 2'b10);
    issue(1, 16'h0101, 16'h0000, 2'b00);   // write with no lanes
    issue(0, 16'h0100, 16'h0, 2'b11);      // expect EFBC
    repeat (4) @(negedge clk);
    for (int k = 0; k < 40; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      issue(lfsr[0], {12'h0, lfsr[7:4]}, {lfsr[3:0], lfsr[15:4]}, lfsr[9:8]);
      if (lfsr[11]) repeat (2) @(negedge clk);
    end
    while (sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check_idle_pins("R1 idle after traffic");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired, actual=running expected=done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule